// File: doc/BRIEF.md
# Parallel LCD Strobe Timing Generator

This block runs a single read or write access on an 8080-style parallel display bus. It drives four control lines: chip select, write strobe, read strobe and the command/data select line. For a write it also drives the data bus. For a read it captures the bus at a programmed moment. Every edge is placed by a tick count taken from two packed timing words. A tick is one interface clock, or two clocks when the granularity bit is set.

A host holds the timing words and a configuration word at the inputs. It then pulses `start` together with a direction, a command/data flag and a write word. The block copies the timing values into its own registers at that moment. Before copying, it repairs any value that would give a zero-width strobe or an illegal order. It then counts ticks from 0 and raises `done` for one clock when the access ends. For a read, the captured word remains on `rd_data` until a later read captures another word.

Top module: `lcd_strobe_gen`

## Requirements
- R1: While and right after reset, `busy`, `done` and `bus_oe` are 0, `rd_data` is 0, and each of the four control lines sits at its idle level. The idle level of a line is the inverse of its polarity bit: `dc_line` idles at 1 XOR bit 16.
- R2: The on/off word holds six fields. CS-on is [3:0] and CS-off is [9:4]. WE-on is [13:10] and WE-off is [19:14]. RE-on is [23:20] and RE-off is [29:24]. The on fields are 4 bits wide and the off fields are 6 bits wide.
- R3: The cycle word holds the write cycle length in [5:0], the read cycle length in [11:6] and the access time in [27:22]. An access lasts its direction's (repaired) cycle length in ticks. `busy` is 1 for that whole time. `done` is 1 for exactly the single clock that follows.
- R4: Ticks are numbered from 0 inside an access. A strobe is active on tick t when on <= t < off. CS is used in both directions, WE only in writes and RE only in reads. Outside an access no strobe is active.
- R5: Each off value is raised to at least its own on value plus 1, for WE, RE and CS.
- R6: CS-off is raised to at least the larger of the repaired WE-off and RE-off.
- R7: Each cycle length is raised to at least the repaired off value of its own strobe. The access time is raised to at least RE-on plus 1.
- R8: When configuration bit 4 is 1, each tick lasts two clocks; when it is 0, each tick lasts one clock.
- R9: Configuration bits 19, 18, 17 and 16 set the polarity of CS, WE, RE and command/data select. A bit of 0 makes that line active-low; a bit of 1 makes it active-high.
- R10: In a read, `rd_data` takes the value of `bus_din` at the clock edge that begins tick number access-time. If the access time exceeds the read cycle length, nothing is captured. Writes never change `rd_data`.
- R11: A `start` that arrives while `busy` is 1 has no effect. The running access keeps its own timing, direction and command flag.
- R12: For a write, `bus_oe` is 1 and `bus_dout` shows the write word for the whole access. The logical select is 0 for a command (`start_cmd`=1) and 1 for data, and `dc_line` = select XOR bit 16. The line holds that value until the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an access; accepted only while idle |
| start_rd | input | 1 | 1 = read access, 0 = write access |
| start_cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| wr_data | input | DW | Word to drive in a write |
| onoff_word | input | 32 | Packed strobe on/off tick values |
| cycle_word | input | 32 | Packed cycle lengths and access time |
| cfg_word | input | 32 | Tick granularity (bit 4) and line polarities (bits 16 to 19) |
| bus_din | input | DW | Data bus as driven by the display |
| cs_line | output | 1 | Chip select line |
| we_line | output | 1 | Write strobe line |
| re_line | output | 1 | Read strobe line |
| dc_line | output | 1 | Command/data select line |
| bus_dout | output | DW | Data bus value to drive |
| bus_oe | output | 1 | Data bus output enable |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock pulse after an access ends |
| rd_data | output | DW | Last word captured by a read |

## Verification
The bench targets the repair rules with these inputs:
- off values at or below their on values;
- a CS-off shorter than the data strobes;
- cycle lengths shorter than the strobes;
- all-zero timing words.

A design that left any of these unrepaired would give zero-width strobes, or an access that ends before its strobe is released. Access times equal to and beyond the read cycle length target the capture edge. An off-by-one error there shows up as a word taken from the neighbouring clock. The bench also sweeps every polarity combination, both granularities and pseudo-random timing words, and compares every line at every clock of each access. Finally, it issues a `start` during a running access with the direction and all timing inverted. A design that accepted it would change strobe shape or length mid-access.

// File: rtl/lcd_strobe_pkg.sv
package lcd_strobe_pkg;

  // tick field widths
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;

  // on/off word field positions
  localparam int CS_ON_LSB  = 0;
  localparam int CS_OFF_LSB = 4;
  localparam int WE_ON_LSB  = 10;
  localparam int WE_OFF_LSB = 14;
  localparam int RE_ON_LSB  = 20;
  localparam int RE_OFF_LSB = 24;

  // cycle word field positions
  localparam int WE_CYC_LSB = 0;
  localparam int RE_CYC_LSB = 6;
  localparam int ACC_LSB    = 22;

  // configuration bits
  localparam int GRAN_BIT = 4;
  localparam int POL_DC   = 16;
  localparam int POL_RE   = 17;
  localparam int POL_WE   = 18;
  localparam int POL_CS   = 19;

  // strobe indices inside the window array
  localparam int S_CS = 0;
  localparam int S_WE = 1;
  localparam int S_RE = 2;
  localparam int N_STROBE = 3;

  typedef struct packed {
    logic [OFF_W-1:0] cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [OFF_W-1:0] we_on;
    logic [OFF_W-1:0] we_off;
    logic [OFF_W-1:0] re_on;
    logic [OFF_W-1:0] re_off;
    logic [OFF_W-1:0] we_cyc;
    logic [OFF_W-1:0] re_cyc;
    logic [OFF_W-1:0] acc;
  } edge_set_t;

  function automatic logic [OFF_W-1:0] tick_max(input logic [OFF_W-1:0] a,
                                                input logic [OFF_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_edge_clamp.sv
module lcd_edge_clamp
  import lcd_strobe_pkg::*;
(
  input  logic [31:0] onoff_word,
  input  logic [31:0] cycle_word,
  output edge_set_t   edges
);

  logic [OFF_W-1:0] cs_on, we_on, re_on;
  logic [OFF_W-1:0] cs_off_r, we_off_r, re_off_r;
  logic [OFF_W-1:0] we_cyc_r, re_cyc_r, acc_r;
  logic [OFF_W-1:0] we_off_c, re_off_c, cs_off_c;

  always_comb begin
    cs_on    = OFF_W'(onoff_word[CS_ON_LSB +: ON_W]);
    we_on    = OFF_W'(onoff_word[WE_ON_LSB +: ON_W]);
    re_on    = OFF_W'(onoff_word[RE_ON_LSB +: ON_W]);
    cs_off_r = onoff_word[CS_OFF_LSB +: OFF_W];
    we_off_r = onoff_word[WE_OFF_LSB +: OFF_W];
    re_off_r = onoff_word[RE_OFF_LSB +: OFF_W];
    we_cyc_r = cycle_word[WE_CYC_LSB +: OFF_W];
    re_cyc_r = cycle_word[RE_CYC_LSB +: OFF_W];
    acc_r    = cycle_word[ACC_LSB +: OFF_W];

    // every strobe at least one tick wide
    we_off_c = tick_max(we_off_r, we_on + 1'b1);
    re_off_c = tick_max(re_off_r, re_on + 1'b1);
    // chip select spans both data strobes
    cs_off_c = tick_max(tick_max(cs_off_r, cs_on + 1'b1),
                        tick_max(we_off_c, re_off_c));

    edges.cs_on  = cs_on;
    edges.cs_off = cs_off_c;
    edges.we_on  = we_on;
    edges.we_off = we_off_c;
    edges.re_on  = re_on;
    edges.re_off = re_off_c;
    edges.we_cyc = tick_max(we_cyc_r, we_off_c);
    edges.re_cyc = tick_max(re_cyc_r, re_off_c);
    edges.acc    = tick_max(acc_r, re_on + 1'b1);
  end

endmodule

// File: rtl/lcd_tick_div.sv
module lcd_tick_div (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div2,
  output logic tick_end
);

  logic half_q;

  always_ff @(posedge clk) begin
    if (rst || !run) half_q <= 1'b0;
    else             half_q <= div2 & ~half_q;
  end

  // last clock of the current tick
  assign tick_end = run & (~div2 | half_q);

endmodule

// File: rtl/lcd_strobe_win.sv
module lcd_strobe_win #(
  parameter int W = 6
) (
  input  logic [W-1:0] t,
  input  logic [W-1:0] on,
  input  logic [W-1:0] off,
  input  logic         en,
  output logic         hit
);

  assign hit = en && (t >= on) && (t < off);

endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
  import lcd_strobe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_rd,
  input  logic          start_cmd,
  input  logic [DW-1:0] wr_data,
  input  logic [31:0]   onoff_word,
  input  logic [31:0]   cycle_word,
  input  logic [31:0]   cfg_word,
  input  logic [DW-1:0] bus_din,
  output logic          cs_line,
  output logic          we_line,
  output logic          re_line,
  output logic          dc_line,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data
);

  localparam int CW = OFF_W + 1;

  edge_set_t clamp_edges, tim_q, tim_use;
  logic act_q, rd_q, div2_q, dc_q, done_q, oe_q;
  logic [OFF_W-1:0] cnt_q, cnt_n, cyc_cur;
  logic [DW-1:0] dout_q, rd_q_data;
  logic [N_STROBE-1:0] str_q, str_n, w_en;
  logic [OFF_W-1:0] w_on [N_STROBE];
  logic [OFF_W-1:0] w_off [N_STROBE];
  logic accept, tick_end, last, act_n, rd_use, capture;

  lcd_edge_clamp u_clamp (
    .onoff_word (onoff_word),
    .cycle_word (cycle_word),
    .edges      (clamp_edges)
  );

  lcd_tick_div u_tick (
    .clk      (clk),
    .rst      (rst),
    .run      (act_q),
    .div2     (div2_q),
    .tick_end (tick_end)
  );

  assign accept  = start && !act_q;
  assign cyc_cur = rd_q ? tim_q.re_cyc : tim_q.we_cyc;
  assign last    = tick_end && (CW'(cnt_q) + 1'b1 == CW'(cyc_cur));
  assign capture = act_q && rd_q && tick_end && (CW'(cnt_q) + 1'b1 == CW'(tim_q.acc));
  assign tim_use = accept ? clamp_edges : tim_q;
  assign rd_use  = accept ? start_rd : rd_q;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    if (accept) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (tick_end) begin
      if (last) begin
        act_n = 1'b0;
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    w_on[S_CS]  = tim_use.cs_on;  w_off[S_CS] = tim_use.cs_off;
    w_on[S_WE]  = tim_use.we_on;  w_off[S_WE] = tim_use.we_off;
    w_on[S_RE]  = tim_use.re_on;  w_off[S_RE] = tim_use.re_off;
    w_en[S_CS]  = act_n;
    w_en[S_WE]  = act_n && !rd_use;
    w_en[S_RE]  = act_n && rd_use;
  end

  for (genvar g = 0; g < N_STROBE; g++) begin : g_win
    lcd_strobe_win #(.W(OFF_W)) u_win (
      .t   (cnt_n),
      .on  (w_on[g]),
      .off (w_off[g]),
      .en  (w_en[g]),
      .hit (str_n[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      cnt_q     <= '0;
      tim_q     <= '0;
      rd_q      <= 1'b0;
      div2_q    <= 1'b0;
      dc_q      <= 1'b1;
      done_q    <= 1'b0;
      oe_q      <= 1'b0;
      str_q     <= '0;
      dout_q    <= '0;
      rd_q_data <= '0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      done_q <= last;
      str_q  <= str_n;
      oe_q   <= act_n && !rd_use;
      if (accept) begin
        tim_q  <= clamp_edges;
        rd_q   <= start_rd;
        div2_q <= cfg_word[GRAN_BIT];
        dc_q   <= !start_cmd;
        dout_q <= wr_data;
      end
      if (capture) rd_q_data <= bus_din;
    end
  end

  // polarity bit 0 selects an active-low line
  assign cs_line  = ~(str_q[S_CS] ^ cfg_word[POL_CS]);
  assign we_line  = ~(str_q[S_WE] ^ cfg_word[POL_WE]);
  assign re_line  = ~(str_q[S_RE] ^ cfg_word[POL_RE]);
  assign dc_line  = dc_q ^ cfg_word[POL_DC];
  assign bus_dout = dout_q;
  assign bus_oe   = oe_q;
  assign busy     = act_q;
  assign done     = done_q;
  assign rd_data  = rd_q_data;

endmodule

// File: rtl/lcd_strobe_gen_chk.sv
module lcd_strobe_gen_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          rd_dir,
  input logic [2:0]    str,
  input logic [DW-1:0] rd_data
);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  end_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4
  dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(str[1] && str[2]));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (str == 3'b000));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rd_data));

  // R11
  dir_lock_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_dir));

endmodule

bind lcd_strobe_gen lcd_strobe_gen_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .rd_dir  (rd_q),
  .str     (str_q),
  .rd_data (rd_data)
);

// File: tb/lcd_strobe_gen_bench.sv
`timescale 1ns/1ps
module lcd_strobe_gen_bench;
  localparam int DW = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, start_rd = 1'b0, start_cmd = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [31:0] onoff_word = '0, cycle_word = '0, cfg_word = '0;
  logic [DW-1:0] bus_din, bus_dout, rd_data;
  logic cs_line, we_line, re_line, dc_line, bus_oe, busy, done;

  int n_chk = 0, n_err = 0, din_ctr = 0;
  bit finished = 0;
  logic [DW-1:0] rd_prev = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) din_ctr <= din_ctr + 1;

  function automatic logic [15:0] din_val(input int n);
    return 16'(n * 40503 + 4660);
  endfunction
  assign bus_din = din_val(din_ctr);

  lcd_strobe_gen #(.DW(DW)) u_lcd_strobe_gen (
    .clk, .rst, .start, .start_rd, .start_cmd, .wr_data, .onoff_word,
    .cycle_word, .cfg_word, .bus_din, .cs_line, .we_line, .re_line,
    .dc_line, .bus_dout, .bus_oe, .busy, .done, .rd_data
  );

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic logic pin(input bit act, input bit inv);
    return ~(act ^ inv);
  endfunction
  function automatic bit win(input int t, input int on, input int off);
    return (t >= on) && (t < off);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pack_oo(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14)
         | (32'(reon) << 20) | (32'(reoff) << 24);
  endfunction
  function automatic logic [31:0] pack_cy(int wecyc, int recyc, int acc);
    return 32'(wecyc) | (32'(recyc) << 6) | (32'(acc) << 22);
  endfunction

  task automatic run_access(input logic [31:0] oo, input logic [31:0] cy, input logic [31:0] cf,
                            input bit rd, input bit cmd, input logic [15:0] wd,
                            input bit poke, input string tag);
    int cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, acc, p, len, base, t;
    logic [6:0] exp_v, obs_v;
    bit dcl;
    cson = int'(oo[3:0]);   csoff = int'(oo[9:4]);
    weon = int'(oo[13:10]); weoff = int'(oo[19:14]);
    reon = int'(oo[23:20]); reoff = int'(oo[29:24]);
    wecyc = int'(cy[5:0]);  recyc = int'(cy[11:6]); acc = int'(cy[27:22]);
    weoff = mx(weoff, weon + 1);
    reoff = mx(reoff, reon + 1);
    csoff = mx(mx(csoff, cson + 1), mx(weoff, reoff));
    acc   = mx(acc, reon + 1);
    wecyc = mx(wecyc, weoff);
    recyc = mx(recyc, reoff);
    p   = cf[4] ? 2 : 1;
    len = (rd ? recyc : wecyc) * p;
    dcl = !cmd;
    @(negedge clk);
    onoff_word = oo; cycle_word = cy; cfg_word = cf;
    start_rd = rd; start_cmd = cmd; wr_data = wd; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    base = din_ctr - 1;
    for (int j = 0; j < len; j++) begin
      if (j > 0) @(negedge clk);
      t = j / p;
      exp_v = {pin(win(t, cson, csoff), cf[19]), pin(!rd && win(t, weon, weoff), cf[18]),
               pin(rd && win(t, reon, reoff), cf[17]), dcl ^ cf[16], 1'b1, 1'b0, !rd};
      obs_v = {cs_line, we_line, re_line, dc_line, busy, done, bus_oe};
      chk(obs_v == exp_v, tag, 32'(obs_v), 32'(exp_v));
      if (!rd) chk(bus_dout == wd, "R12 write data", 32'(bus_dout), 32'(wd));
      if (poke && j == 1) begin
        start = 1'b1; start_rd = !rd; start_cmd = !cmd;
        onoff_word = ~oo; cycle_word = ~cy;
      end
      if (poke && j == 2) begin
        start = 1'b0; start_rd = rd; start_cmd = cmd;
        onoff_word = oo; cycle_word = cy;
      end
    end
    @(negedge clk);
    exp_v = {pin(0, cf[19]), pin(0, cf[18]), pin(0, cf[17]), dcl ^ cf[16], 1'b0, 1'b1, 1'b0};
    obs_v = {cs_line, we_line, re_line, dc_line, busy, done, bus_oe};
    chk(obs_v == exp_v, poke ? "R11 end" : tag, 32'(obs_v), 32'(exp_v));
    if (rd && acc <= recyc) rd_prev = din_val(base + acc * p);
    chk(rd_data == rd_prev, "R10 capture", 32'(rd_data), 32'(rd_prev));
    @(negedge clk);
    chk(!done && !busy, poke ? "R11 idle" : "R3 done pulse", 32'({busy, done}), 32'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed, oo, cy, cf;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({cs_line, we_line, re_line, dc_line, busy, done, bus_oe} == 7'b1111000, "R1 lines",
        32'({cs_line, we_line, re_line, dc_line, busy, done, bus_oe}), 32'h78);
    chk(rd_data == '0, "R1 rd_data", 32'(rd_data), 0);

    // R2 field placement, directed write and read
    run_access(pack_oo(1, 9, 2, 6, 3, 7), pack_cy(10, 12, 5), 0, 0, 0, 16'hA5C3, 0, "R2 write");
    run_access(pack_oo(2, 11, 1, 5, 3, 8), pack_cy(9, 12, 6), 0, 1, 0, 16'h0, 0, "R2 read");
    // R5 all zero words give one-tick strobes
    run_access(0, 0, 0, 0, 0, 16'h1111, 0, "R5 zero write");
    run_access(0, 0, 0, 1, 0, 16'h0, 0, "R5 zero read");
    // R5 off below on
    run_access(pack_oo(6, 2, 5, 3, 0, 0), pack_cy(0, 0, 0), 0, 0, 0, 16'h2222, 0, "R5 inverted edges");
    run_access(pack_oo(0, 0, 0, 0, 9, 4), pack_cy(0, 0, 0), 0, 1, 0, 16'h0, 0, "R5 inverted read");
    // R6 chip select stretched over data strobes
    run_access(pack_oo(0, 2, 1, 8, 0, 0), pack_cy(12, 0, 0), 0, 0, 0, 16'h3333, 0, "R6 cs stretch");
    run_access(pack_oo(1, 3, 0, 0, 2, 14), pack_cy(0, 20, 3), 0, 1, 0, 16'h0, 0, "R6 cs stretch read");
    // R7 cycle raised, access time raised
    run_access(pack_oo(0, 7, 0, 7, 0, 0), pack_cy(2, 0, 0), 0, 0, 0, 16'h4444, 0, "R7 short cycle");
    run_access(pack_oo(0, 0, 0, 0, 3, 6), pack_cy(0, 1, 0), 0, 1, 0, 16'h0, 0, "R7 access raised");
    // R8 doubled ticks
    run_access(pack_oo(1, 9, 2, 6, 3, 7), pack_cy(10, 12, 5), 32'h10, 0, 0, 16'h5555, 0, "R8 div2 write");
    run_access(pack_oo(1, 9, 2, 6, 3, 7), pack_cy(10, 12, 5), 32'h10, 1, 0, 16'h0, 0, "R8 div2 read");
    // R9 every polarity combination
    for (int pp = 0; pp < 16; pp++)
      run_access(pack_oo(1, 6, 2, 5, 1, 4), pack_cy(7, 6, 3), 32'(pp) << 16,
                 pp[0], pp[1], 16'(pp * 4097), 0, "R9 polarity");
    // R10 access time beyond cycle: no capture; equal: capture at end edge
    run_access(pack_oo(0, 0, 0, 0, 1, 4), pack_cy(0, 5, 9), 0, 1, 0, 16'h0, 0, "R10 late access");
    run_access(pack_oo(0, 0, 0, 0, 1, 4), pack_cy(0, 5, 5), 32'h10, 1, 0, 16'h0, 0, "R10 access at end");
    run_access(pack_oo(0, 0, 0, 0, 0, 0), pack_cy(3, 0, 0), 0, 0, 0, 16'h7777, 0, "R10 write keeps rd_data");
    // R11 start during an access is ignored
    run_access(pack_oo(1, 9, 2, 6, 3, 7), pack_cy(10, 12, 5), 0, 0, 1, 16'h6666, 1, "R11 poke write");
    run_access(pack_oo(1, 9, 2, 6, 3, 7), pack_cy(10, 12, 5), 32'h10, 1, 0, 16'h0, 1, "R11 poke read");
    // R12 command vs data select
    run_access(pack_oo(0, 3, 1, 2, 0, 0), pack_cy(4, 0, 0), 0, 0, 1, 16'hC0DE, 0, "R12 command");
    run_access(pack_oo(0, 3, 1, 2, 0, 0), pack_cy(4, 0, 0), 0, 0, 0, 16'hDA7A, 0, "R12 data");
    // R3 pseudo-random sweep of timing words
    seed = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345; oo = seed;
      seed = seed * 32'd1103515245 + 32'd12345; cy = seed;
      seed = seed * 32'd1103515245 + 32'd12345; cf = seed & 32'h000F_0010;
      run_access(oo, cy, cf, k[0], k[1], 16'(seed >> 8), 0, "R3 sweep");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule